// File: doc/BRIEF.md
# Clocked-to-Dual-Rail Word Bridge

This block connects a producer that runs on a clock to a consumer that takes 4-phase dual-rail data and answers with a single acknowledge line. The producer hands over single-rail words with a valid/ready handshake. The words wait in a first-in first-out store whose depth is a parameter. The store absorbs bursts while the producer runs faster than the consumer and empties once the consumer catches up.

On the consumer side, every word leaves as a pair of rails per bit. A 1 bit drives its true rail high and a 0 bit drives its false rail high. Between two words, both rails of every bit sit low; this is the spacer. The sender presents a codeword and holds it until the acknowledge goes high. It then returns all rails to spacer and waits for the acknowledge to fall before it presents the next word.

The acknowledge is sampled in the block's own clock domain. A fill count and a watermark flag show how far the store has backed up, so a slow consumer can be noticed.

Top module: `sync_dualrail_fifo_bridge`

## Requirements
- R1: Bit i of a sent word appears on bit i of the rails. A 1 is sent as rail_t=1, rail_f=0 and a 0 as rail_t=0, rail_f=1. The spacer is every rail_t and rail_f bit at 0. No bit ever has both rails high.
- R2: After reset, all rails are at spacer, fill is 0, high_mark is 0 and wr_ready is 1.
- R3: A word is stored on a rising clock edge where wr_valid and wr_ready are both high. wr_ready is low while fill equals DEPTH. A word offered while wr_ready is low is dropped: fill does not change and the word is never sent.
- R4: Words reach the rails in the order they were accepted, with no loss and no duplication.
- R5: A codeword on the rails stays unchanged for as long as rd_ack is low.
- R6: On the first clock after rd_ack is seen high during a codeword, the rails return to spacer. They stay at spacer while rd_ack is high. A new codeword appears only after rd_ack has been seen low, so every word is followed by at least one spacer cycle.
- R7: While no word is stored or being sent, the rails stay at spacer.
- R8: fill is the number of words held in the store, not counting the word being sent. It changes by at most one per clock and never exceeds DEPTH. high_mark is 1 exactly when fill >= HIGH_MARK.
- R9: When the sender is idle, rd_ack is low and the store holds a word, that word's codeword appears on the rails one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | WIDTH | Single-rail word from the producer |
| wr_valid | input | 1 | Producer offers wr_data |
| wr_ready | output | 1 | Store has room; a write is accepted |
| rail_t | output | WIDTH | True rail of each dual-rail bit |
| rail_f | output | WIDTH | False rail of each dual-rail bit |
| rd_ack | input | 1 | Acknowledge from the dual-rail consumer |
| fill | output | $clog2(DEPTH+1) | Words currently held in the store |
| high_mark | output | 1 | Fill has reached HIGH_MARK |

## Verification
The bench builds the block with WIDTH=8, DEPTH=4 and HIGH_MARK=3. This non-default depth is a power of two, and it lets a few writes fill the store while the consumer is held back. That brings the full condition, the dropped write and the watermark edge between fill 2 and fill 3 within easy reach. The all-zeros, all-ones and alternating patterns exercise both rails of every bit. The consumer's acknowledge delay varies from word to word, so the hold and return-to-spacer rules are checked with zero-cycle and multi-cycle waits.

// File: rtl/sdr_bridge_pkg.sv
package sdr_bridge_pkg;
   typedef enum logic [1:0] {
      TX_IDLE   = 2'd0,
      TX_WORD   = 2'd1,
      TX_SPACER = 2'd2
   } tx_state_e;
endpackage

// File: rtl/sdr_fifo_store.sv
module sdr_fifo_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count,
   output logic             not_full,
   output logic             not_empty
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;

   // pointer wrap: free binary wrap for powers of two, compare otherwise
   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         always_comb begin
            wptr_nx = wptr + 1'b1;
            rptr_nx = rptr + 1'b1;
         end
      end else begin : g_cmp
         always_comb begin
            wptr_nx = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            rptr_nx = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head      = mem[rptr];
   assign not_full  = (count != FULL_CNT);
   assign not_empty = (count != '0);
endmodule

// File: rtl/sdr_tx_ctrl.sv
module sdr_tx_ctrl
   import sdr_bridge_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             have_word,
   input  logic [WIDTH-1:0] head,
   input  logic             ack,
   output logic             take,
   output logic [WIDTH-1:0] word_q,
   output logic             drive
);
   tx_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      take     = 1'b0;
      unique case (state)
         TX_IDLE: if (have_word && !ack) begin
            take     = 1'b1;
            state_nx = TX_WORD;
         end
         TX_WORD:   if (ack)  state_nx = TX_SPACER;
         TX_SPACER: if (!ack) state_nx = TX_IDLE;
         default:   state_nx = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= TX_IDLE;
         word_q <= '0;
      end else begin
         state <= state_nx;
         if (take) word_q <= head;
      end
   end

   assign drive = (state == TX_WORD);
endmodule

// File: rtl/sdr_rail_enc.sv
module sdr_rail_enc #(
   parameter int WIDTH = 8
) (
   input  logic             drive,
   input  logic [WIDTH-1:0] word,
   output logic [WIDTH-1:0] rail_t,
   output logic [WIDTH-1:0] rail_f
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign rail_t[b] = drive &  word[b];
         assign rail_f[b] = drive & ~word[b];
      end
   endgenerate
endmodule

// File: rtl/sync_dualrail_fifo_bridge.sv
module sync_dualrail_fifo_bridge #(
   parameter int WIDTH     = 8,
   parameter int DEPTH     = 8,
   parameter int HIGH_MARK = 6,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic [WIDTH-1:0] rail_t,
   output logic [WIDTH-1:0] rail_f,
   input  logic             rd_ack,
   output logic [CW-1:0]    fill,
   output logic             high_mark
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (HIGH_MARK < 1 || HIGH_MARK > DEPTH) begin : g_bad_mark
         $error("HIGH_MARK must lie in 1..DEPTH");
      end
   endgenerate

   localparam logic [CW-1:0] MARK_CNT = CW'(HIGH_MARK);

   logic             push, pop, not_empty, drive;
   logic [WIDTH-1:0] head, word_q;

   assign push = wr_valid & wr_ready;

   sdr_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (wr_data),
      .pop       (pop),
      .head      (head),
      .count     (fill),
      .not_full  (wr_ready),
      .not_empty (not_empty)
   );

   sdr_tx_ctrl #(.WIDTH(WIDTH)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .have_word (not_empty),
      .head      (head),
      .ack       (rd_ack),
      .take      (pop),
      .word_q    (word_q),
      .drive     (drive)
   );

   sdr_rail_enc #(.WIDTH(WIDTH)) u_enc (
      .drive  (drive),
      .word   (word_q),
      .rail_t (rail_t),
      .rail_f (rail_f)
   );

   assign high_mark = (fill >= MARK_CNT);
endmodule

// File: rtl/sync_dualrail_fifo_bridge_chk.sv
module sync_dualrail_fifo_bridge_chk #(
   parameter int WIDTH     = 8,
   parameter int DEPTH     = 8,
   parameter int HIGH_MARK = 6,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_ready,
   input logic [WIDTH-1:0] rail_t,
   input logic [WIDTH-1:0] rail_f,
   input logic             rd_ack,
   input logic [CW-1:0]    fill
);
   logic is_code, is_space;
   assign is_code  = ((rail_t ^ rail_f) == {WIDTH{1'b1}});
   assign is_space = ((rail_t | rail_f) == '0);

   // R1
   rails_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rail_t & rail_f) == '0) && (is_code || is_space));

   // R3
   full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CW'(DEPTH)) |-> !wr_ready);

   // R5
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_code && !rd_ack) |=> ($stable(rail_t) && $stable(rail_f)));

   // R6
   spacer_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_code |=> (is_space || ($stable(rail_t) && $stable(rail_f))));

   // R6
   launch_needs_low_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_code && $past(is_space)) |-> !$past(rd_ack));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

   // R8
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == $past(fill)) || (fill == $past(fill) + 1'b1) || (fill + 1'b1 == $past(fill)));
endmodule

bind sync_dualrail_fifo_bridge sync_dualrail_fifo_bridge_chk #(
   .WIDTH(WIDTH), .DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_ready (wr_ready),
   .rail_t   (rail_t),
   .rail_f   (rail_f),
   .rd_ack   (rd_ack),
   .fill     (fill)
);

// File: tb/sim_sync_dualrail_fifo_bridge.sv
`timescale 1ns/1ps
module sim_sync_dualrail_fifo_bridge;
   localparam int W  = 8;
   localparam int D  = 4;
   localparam int HM = 3;
   localparam int CW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic          wr_valid = 1'b0;
   logic          wr_ready;
   logic [W-1:0]  rail_t, rail_f;
   logic          rd_ack = 1'b0;
   logic [CW-1:0] fill;
   logic          high_mark;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] exp_q[$];
   bit consumer_en = 1'b0;
   int words_seen = 0;

   always #5 clk = ~clk;

   sync_dualrail_fifo_bridge #(.WIDTH(W), .DEPTH(D), .HIGH_MARK(HM)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .rail_t(rail_t), .rail_f(rail_f),
      .rd_ack(rd_ack), .fill(fill), .high_mark(high_mark)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit spacer_now();
      return (rail_t | rail_f) == '0;
   endfunction

   // driver: offer a word until accepted, then record it for the scoreboard
   task automatic put(input logic [W-1:0] d);
      bit rdy;
      @(negedge clk);
      wr_data  = d;
      wr_valid = 1'b1;
      forever begin
         rdy = wr_ready;
         @(posedge clk);
         if (rdy) break;
         @(negedge clk);
      end
      exp_q.push_back(d);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // monitor: decode codewords, compare with scoreboard, then acknowledge
   initial begin
      forever begin
         @(negedge clk);
         if (consumer_en && rst_n && !spacer_now()) begin
            logic [W-1:0] got, exp;
            int wait_n;
            // R1: every bit must carry exactly one high rail
            chk((rail_t ^ rail_f) == '1, "R1 codeword", {rail_t, rail_f}, '1);
            got = rail_t;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected word", got, 0);
            end else begin
               exp = exp_q.pop_front();
               chk(got == exp, "R4 order", got, exp);
            end
            wait_n = words_seen % 3;
            words_seen++;
            for (int k = 0; k < wait_n; k++) begin
               @(negedge clk);
               chk(rail_t == got && (rail_f == ~got), "R5 hold", rail_t, got);
            end
            rd_ack = 1'b1;
            @(negedge clk);
            chk(spacer_now(), "R6 spacer after ack", {rail_t, rail_f}, 0);
            @(negedge clk);
            chk(spacer_now(), "R6 spacer while ack high", {rail_t, rail_f}, 0);
            rd_ack = 1'b0;
            @(negedge clk);
            chk(spacer_now(), "R6 spacer after ack low", {rail_t, rail_f}, 0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic drain();
      int guard = 0;
      while ((exp_q.size() != 0 || !spacer_now() || fill != 0) && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
   endtask

   initial begin
      logic [W-1:0] held;
      logic [W-1:0] lfsr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2 reset state (rails sampled while reset is still held)
      chk(spacer_now(), "R2 rails at reset", {rail_t, rail_f}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(spacer_now(), "R2 rails after reset", {rail_t, rail_f}, 0);
      chk(fill == 0, "R2 fill", fill, 0);
      chk(high_mark == 1'b0, "R2 high_mark", high_mark, 0);
      chk(wr_ready == 1'b1, "R2 wr_ready", wr_ready, 1);
      repeat (4) begin
         @(negedge clk);
         chk(spacer_now(), "R7 idle spacer", {rail_t, rail_f}, 0);
      end

      // R9 latency with the consumer held back
      put(8'hA5);
      chk(spacer_now(), "R9 not yet sent", {rail_t, rail_f}, 0);
      chk(fill == 1, "R8 fill one", fill, 1);
      @(negedge clk);
      chk(rail_t == 8'hA5 && rail_f == 8'h5A, "R9 codeword one clock later", rail_t, 8'hA5);
      chk(fill == 0, "R8 fill after launch", fill, 0);

      // R3/R8 fill to the limit while the consumer waits
      put(8'h00);
      put(8'hFF);
      chk(fill == 2 && !high_mark, "R8 below mark", {fill, high_mark}, {CW'(2), 1'b0});
      put(8'h5A);
      chk(fill == 3 && high_mark, "R8 at mark", {fill, high_mark}, {CW'(3), 1'b1});
      put(8'h3C);
      chk(fill == D, "R8 full count", fill, D);
      chk(wr_ready == 1'b0, "R3 ready low when full", wr_ready, 0);
      held = rail_t;
      repeat (3) @(negedge clk);
      chk(rail_t == held && rail_f == ~held, "R5 hold while ack low", rail_t, held);

      // R3 write while full is dropped
      wr_data  = 8'hEE;
      wr_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      chk(fill == D, "R3 dropped write keeps fill", fill, D);

      consumer_en = 1'b1;
      drain();
      repeat (5) @(negedge clk);
      chk(spacer_now(), "R7 spacer when empty", {rail_t, rail_f}, 0);
      chk(fill == 0 && wr_ready, "R7 empty store", fill, 0);

      // mixed patterns with a running consumer
      lfsr = 8'h1D;
      for (int n = 0; n < 24; n++) begin
         put(lfsr);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      put(8'h01);
      put(8'h80);
      drain();
      chk(high_mark == 1'b0, "R8 mark cleared", high_mark, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule